// File: doc/BRIEF.md
# DMA Chained-Descriptor Loader

This block lets a DMA channel run a chain of transfers without software taking part between blocks. The channel's per-block register set (control word, transfer size, 64-bit source, 64-bit destination and 64-bit link pointer) lives here and drives the data-moving engine. When the engine reports that the current block has finished, the loader looks at the link pointer. If the pointer is zero, the chain is over and the terminal-count status is raised. Otherwise the loader reads an eight-word descriptor from memory, one 32-bit word at a time through a simple request/acknowledge read port, and then restarts the channel with the new values.

A descriptor has the same layout as the channel's register set, so the loaded words go straight into the registers. Word 0 is the control word and word 1 is the transfer size, counted in units of the channel's data width. Words 2 and 3 are the source address (low word, then high word). Words 4 and 5 are the destination address, low then high. Words 6 and 7 are the next link pointer, low then high. Because each block brings its own control word, source and destination address stepping can change from one block to the next.

The read port can return an error. A failed fetch stops the channel and raises the error status, and so does a link pointer that is not aligned to the descriptor boundary. Software starts a chain by writing a full register set through the initial-load port.

Top module: `dlc_chain_loader`

## Requirements
- R1: After reset the channel is stopped (`ch_run`=0), no read is requested, and both `chain_done` and `chain_err` are 0.
- R2: A cycle with `init_we`=1 loads all five channel registers from the `init_*` inputs, clears `chain_done` and `chain_err`, and sets `ch_run` from the next cycle on.
- R3: A `blk_done` pulse while the channel runs with a link pointer of zero (both halves) stops the channel, sets `chain_done`, and issues no read.
- R4: A `blk_done` pulse with a non-zero, aligned link pointer stops the channel and issues exactly eight single-word reads at the link pointer plus 0, 4, 8 ... 28, in ascending order and one at a time. The channel stays stopped for the whole fetch.
- R5: Descriptor word 0 replaces the control word whole, word 1 the size, words 2/3 the source low/high, words 4/5 the destination low/high, and words 6/7 the link pointer low/high.
- R6: The channel registers keep their old values for the whole fetch. `ch_run` returns to 1 exactly two cycles after the cycle in which the eighth read is acknowledged, and the new register values appear at that same moment.
- R7: `chain_done` stays 0 after intermediate blocks. It is set only when a block ends with a zero link pointer.
- R8: A read acknowledged with `rd_err`=1 ends the fetch at once. The channel stays stopped, `chain_err` is set, and every channel register keeps its pre-fetch value.
- R9: A non-zero link pointer whose low three bits are not all zero (descriptors are 8-byte aligned) sets `chain_err` when the block ends, and no read is issued.
- R10: `blk_done` has no effect while the channel is stopped: no read, no status change, no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_we | input | 1 | Load the initial register set and start the channel |
| init_ctrl | input | 32 | Initial control word |
| init_size | input | 32 | Initial transfer size in data-width units |
| init_src | input | 64 | Initial source address |
| init_dst | input | 64 | Initial destination address |
| init_link | input | 64 | Initial link pointer |
| blk_done | input | 1 | Engine pulse: current block finished |
| ch_run | output | 1 | Channel enable to the engine |
| ch_ctrl | output | 32 | Current control word |
| ch_size | output | 32 | Current transfer size |
| ch_src | output | 64 | Current source address |
| ch_dst | output | 64 | Current destination address |
| ch_link | output | 64 | Current link pointer |
| chain_done | output | 1 | Sticky terminal-count status of the chain |
| chain_err | output | 1 | Sticky error status (fetch error or misaligned link) |
| rd_req | output | 1 | Descriptor read request, held until acknowledged |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_ack | input | 1 | Read acknowledge |
| rd_data | input | 32 | Read data, valid with `rd_ack` |
| rd_err | input | 1 | Error response, valid with `rd_ack` |

## Verification
The assertions check on every cycle that:
- the channel never runs while a read is requested;
- the channel registers stay frozen while a fetch is in progress;
- successive read addresses step by four;
- the channel restarts only from an initial load or a completed fetch;
- terminal count rises only with a zero link pointer;
- an error leaves the channel idle;
- a misaligned link never leads to a read.

Whether the right descriptor word lands in each register, the exact restart latency, the count of reads before an error, and the absence of any effect from a stray `blk_done` can only be shown by the bench scenarios: one two-descriptor chain, one fetch that fails on its fourth word, and one misaligned pointer.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
   localparam int WORD_W     = 32;
   localparam int PTR_W      = 64;
   localparam int DESC_WORDS = 8;
   localparam int IDX_W      = $clog2(DESC_WORDS);

   typedef struct packed {
      logic [WORD_W-1:0] ctrl;
      logic [WORD_W-1:0] size;
      logic [PTR_W-1:0]  src;
      logic [PTR_W-1:0]  dst;
      logic [PTR_W-1:0]  link;
   } chan_regs_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RUN    = 2'd1,
      ST_FETCH  = 2'd2,
      ST_COMMIT = 2'd3
   } ld_state_t;
endpackage

// File: rtl/dlc_seq.sv
module dlc_seq
   import dlc_pkg::*;
#(
   parameter int ALIGN_BYTES = 8,
   parameter bit CHECK_ALIGN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_we,
   input  logic             blk_done,
   input  logic [PTR_W-1:0] link,
   input  logic             rd_ack,
   input  logic             rd_err,
   output logic             rd_req,
   output logic [PTR_W-1:0] rd_addr,
   output logic [IDX_W-1:0] idx,
   output logic             cap_we,
   output logic             commit,
   output logic             blk_end,
   output logic             set_tc,
   output logic             set_err
);
   localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
   localparam int PAD_W     = PTR_W - IDX_W - 2;

   ld_state_t st;
   logic      misaligned;
   logic      link_zero;

   generate
      if (CHECK_ALIGN) begin : g_align_chk
         assign misaligned = |link[ALIGN_LSB-1:0];
      end else begin : g_align_none
         assign misaligned = 1'b0;
      end
   endgenerate

   assign link_zero = (link == '0);
   assign rd_req    = (st == ST_FETCH);
   assign rd_addr   = link + {{PAD_W{1'b0}}, idx, 2'b00};
   assign blk_end   = (st == ST_RUN) && blk_done && !init_we;
   assign set_tc    = blk_end && link_zero;
   assign cap_we    = (st == ST_FETCH) && rd_ack && !rd_err && !init_we;
   assign set_err   = (blk_end && !link_zero && misaligned) ||
                      ((st == ST_FETCH) && rd_ack && rd_err && !init_we);
   assign commit    = (st == ST_COMMIT) && !init_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         idx <= '0;
      end else if (init_we) begin
         st  <= ST_RUN;
         idx <= '0;
      end else begin
         case (st)
            ST_RUN: begin
               if (blk_done) begin
                  if (link_zero || misaligned) st <= ST_IDLE;
                  else begin
                     st  <= ST_FETCH;
                     idx <= '0;
                  end
               end
            end
            ST_FETCH: begin
               if (rd_ack) begin
                  if (rd_err)                             st  <= ST_IDLE;
                  else if (idx == IDX_W'(DESC_WORDS - 1)) st  <= ST_COMMIT;
                  else                                    idx <= idx + 1'b1;
               end
            end
            ST_COMMIT: st <= ST_RUN;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   // R9: a misaligned non-zero link never starts a fetch
   assert_misalign_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && !link_zero && misaligned) |=> !rd_req);

   // R4: a fetch never runs past the last descriptor word
   assert_idx_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && !rd_err && !init_we && idx == IDX_W'(DESC_WORDS - 1)) |=> !rd_req);
endmodule

// File: rtl/dlc_shadow.sv
module dlc_shadow
   import dlc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] rd_data,
   output chan_regs_t        desc
);
   logic [WORD_W-1:0] words [DESC_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < DESC_WORDS; w++) words[w] <= '0;
      end else if (cap_we) begin
         for (int w = 0; w < DESC_WORDS; w++)
            if (idx == IDX_W'(w)) words[w] <= rd_data;
      end
   end

   // descriptor order matches the channel register order
   assign desc.ctrl = words[0];
   assign desc.size = words[1];
   assign desc.src  = {words[3], words[2]};
   assign desc.dst  = {words[5], words[4]};
   assign desc.link = {words[7], words[6]};
endmodule

// File: rtl/dlc_regs.sv
module dlc_regs
   import dlc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_we,
   input  chan_regs_t init_val,
   input  logic       commit,
   input  chan_regs_t desc,
   input  logic       blk_end,
   input  logic       set_tc,
   input  logic       set_err,
   output chan_regs_t cur,
   output logic       run,
   output logic       tc,
   output logic       err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
         run <= 1'b0;
         tc  <= 1'b0;
         err <= 1'b0;
      end else if (init_we) begin
         cur <= init_val;
         run <= 1'b1;
         tc  <= 1'b0;
         err <= 1'b0;
      end else begin
         if (commit) begin
            cur <= desc;
            run <= 1'b1;
         end else if (blk_end) begin
            run <= 1'b0;
         end
         if (set_tc)  tc  <= 1'b1;
         if (set_err) err <= 1'b1;
      end
   end
endmodule

// File: rtl/dlc_chain_loader.sv
module dlc_chain_loader
   import dlc_pkg::*;
#(
   parameter int ALIGN_BYTES = 8,
   parameter bit CHECK_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_we,
   input  logic [WORD_W-1:0] init_ctrl,
   input  logic [WORD_W-1:0] init_size,
   input  logic [PTR_W-1:0]  init_src,
   input  logic [PTR_W-1:0]  init_dst,
   input  logic [PTR_W-1:0]  init_link,
   input  logic              blk_done,
   output logic              ch_run,
   output logic [WORD_W-1:0] ch_ctrl,
   output logic [WORD_W-1:0] ch_size,
   output logic [PTR_W-1:0]  ch_src,
   output logic [PTR_W-1:0]  ch_dst,
   output logic [PTR_W-1:0]  ch_link,
   output logic              chain_done,
   output logic              chain_err,
   output logic              rd_req,
   output logic [PTR_W-1:0]  rd_addr,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   input  logic              rd_err
);
   generate
      if (ALIGN_BYTES < 4 || (ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
         $error("ALIGN_BYTES must be a power of two of at least 4");
      end
   endgenerate

   chan_regs_t       init_val, desc, cur;
   logic [IDX_W-1:0] idx;
   logic             cap_we, commit, blk_end, set_tc, set_err;

   assign init_val = '{init_ctrl, init_size, init_src, init_dst, init_link};

   dlc_seq #(.ALIGN_BYTES(ALIGN_BYTES), .CHECK_ALIGN(CHECK_ALIGN)) u_seq (
      .clk(clk), .rst_n(rst_n), .init_we(init_we), .blk_done(blk_done),
      .link(cur.link), .rd_ack(rd_ack), .rd_err(rd_err),
      .rd_req(rd_req), .rd_addr(rd_addr), .idx(idx), .cap_we(cap_we),
      .commit(commit), .blk_end(blk_end), .set_tc(set_tc), .set_err(set_err));

   dlc_shadow u_shadow (
      .clk(clk), .rst_n(rst_n), .cap_we(cap_we), .idx(idx),
      .rd_data(rd_data), .desc(desc));

   dlc_regs u_regs (
      .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_val(init_val),
      .commit(commit), .desc(desc), .blk_end(blk_end), .set_tc(set_tc),
      .set_err(set_err), .cur(cur), .run(ch_run), .tc(chain_done), .err(chain_err));

   assign ch_ctrl = cur.ctrl;
   assign ch_size = cur.size;
   assign ch_src  = cur.src;
   assign ch_dst  = cur.dst;
   assign ch_link = cur.link;

   // R4: channel held stopped while a descriptor is being read
   assert_fetch_holds_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !ch_run);

   // R4: consecutive descriptor reads step by one word
   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && !rd_err && !init_we) |=> (!rd_req || rd_addr == $past(rd_addr) + 64'd4));

   // R6: registers frozen during a fetch
   assert_regs_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !init_we) |=> ($stable(ch_ctrl) && $stable(ch_size) && $stable(ch_src)
                                && $stable(ch_dst) && $stable(ch_link)));

   // R6: channel restarts only from an initial load or a finished fetch
   assert_restart_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_run) |-> ($past(init_we) || $past(commit)));

   // R3: terminal count only with a zero link pointer
   assert_done_zero_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chain_done) |-> ($past(ch_link) == '0));

   // R8: an error leaves the channel idle
   assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chain_err |-> (!ch_run && !rd_req));
endmodule

// File: tb/dlc_chain_loader_test.sv
`timescale 1ns/1ps
module dlc_chain_loader_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_we = 1'b0;
   logic [31:0] init_ctrl = '0, init_size = '0;
   logic [63:0] init_src = '0, init_dst = '0, init_link = '0;
   logic        blk_done = 1'b0;
   logic        ch_run, chain_done, chain_err, rd_req;
   logic [31:0] ch_ctrl, ch_size;
   logic [63:0] ch_src, ch_dst, ch_link, rd_addr;
   logic        rd_ack = 1'b0, rd_err = 1'b0;
   logic [31:0] rd_data = '0;

   int checks = 0, fails = 0;
   int ncyc = 0, last_ack = 0, nreads = 0;
   bit finished = 1'b0;
   logic [63:0] rlog [16];
   logic [31:0] mem [128];
   logic [63:0] err_addr = '1;

   always #10 clk = ~clk;

   dlc_chain_loader uut (
      .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_ctrl(init_ctrl),
      .init_size(init_size), .init_src(init_src), .init_dst(init_dst),
      .init_link(init_link), .blk_done(blk_done), .ch_run(ch_run),
      .ch_ctrl(ch_ctrl), .ch_size(ch_size), .ch_src(ch_src), .ch_dst(ch_dst),
      .ch_link(ch_link), .chain_done(chain_done), .chain_err(chain_err),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .rd_err(rd_err));

   always @(posedge clk) ncyc++;

   // memory responder: one acknowledged word every two cycles
   always @(negedge clk) begin
      if (rd_req && !rd_ack) begin
         rd_ack  = 1'b1;
         rd_data = (rd_addr < 64'd512) ? mem[rd_addr[8:2]] : 32'h0;
         rd_err  = (rd_addr == err_addr) || (rd_addr >= 64'd512);
         if (nreads < 16) rlog[nreads] = rd_addr;
         nreads++;
         last_ack = ncyc;
      end else begin
         rd_ack = 1'b0;
         rd_err = 1'b0;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic put_desc(input int base, input logic [31:0] w0, w1, w2, w3, w4, w5, w6, w7);
      mem[base+0] = w0; mem[base+1] = w1; mem[base+2] = w2; mem[base+3] = w3;
      mem[base+4] = w4; mem[base+5] = w5; mem[base+6] = w6; mem[base+7] = w7;
   endtask

   task automatic load_init(input logic [31:0] c, s, input logic [63:0] sa, da, lk);
      @(negedge clk);
      init_ctrl = c; init_size = s; init_src = sa; init_dst = da; init_link = lk;
      init_we = 1'b1;
      @(negedge clk);
      init_we = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      blk_done = 1'b1;
      @(negedge clk);
      blk_done = 1'b0;
   endtask

   task automatic wait_run();
      for (int i = 0; i < 100; i++) begin
         if (ch_run) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      for (int i = 0; i < 128; i++) mem[i] = 32'h0;
      put_desc(64, 32'h0102_5003, 32'h10, 32'h1111_2222, 32'h3, 32'h4444_5555, 32'h6, 32'h140, 32'h0);
      put_desc(80, 32'h0102_9005, 32'h20, 32'hAAAA_0000, 32'h0, 32'hBBBB_0000, 32'h0, 32'h0, 32'h0);
      put_desc(96, 32'hDEAD_0001, 32'h7, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ch_run", 64'(ch_run), 64'd0);
      chk("R1", "rd_req", 64'(rd_req), 64'd0);
      chk("R1", "chain_done", 64'(chain_done), 64'd0);
      chk("R1", "chain_err", 64'(chain_err), 64'd0);
   endtask

   task automatic t_chain();
      int lat;
      load_init(32'h0102_0001, 32'h8, 64'h1000, 64'h2000, 64'h100);
      chk("R2", "ch_run after load", 64'(ch_run), 64'd1);
      chk("R2", "ch_link", ch_link, 64'h100);
      chk("R2", "ch_src", ch_src, 64'h1000);
      nreads = 0;
      pulse_done();
      chk("R4", "ch_run stopped during fetch", 64'(ch_run), 64'd0);
      chk("R6", "ctrl held during fetch", 64'(ch_ctrl), 64'h0102_0001);
      wait_run();
      lat = ncyc - last_ack;
      chk("R6", "restart latency", 64'(lat), 64'd2);
      chk("R4", "read count", 64'(nreads), 64'd8);
      for (int i = 0; i < 8; i++) chk("R4", "read address", rlog[i], 64'h100 + 64'(4 * i));
      chk("R5", "ctrl word", 64'(ch_ctrl), 64'h0102_5003);
      chk("R5", "size", 64'(ch_size), 64'h10);
      chk("R5", "src", ch_src, 64'h0000_0003_1111_2222);
      chk("R5", "dst", ch_dst, 64'h0000_0006_4444_5555);
      chk("R5", "link", ch_link, 64'h140);
      chk("R7", "no done after intermediate block", 64'(chain_done), 64'd0);
      nreads = 0;
      pulse_done();
      wait_run();
      chk("R4", "second read count", 64'(nreads), 64'd8);
      chk("R4", "second first address", rlog[0], 64'h140);
      chk("R5", "second ctrl word", 64'(ch_ctrl), 64'h0102_9005);
      chk("R5", "second link zero", ch_link, 64'h0);
      chk("R7", "no done before last block", 64'(chain_done), 64'd0);
      nreads = 0;
      pulse_done();
      repeat (4) @(negedge clk);
      chk("R3", "chain_done", 64'(chain_done), 64'd1);
      chk("R3", "ch_run stopped", 64'(ch_run), 64'd0);
      chk("R3", "no read on zero link", 64'(nreads), 64'd0);
      chk("R3", "chain_err clear", 64'(chain_err), 64'd0);
   endtask

   task automatic t_ignore_idle();
      nreads = 0;
      pulse_done();
      repeat (4) @(negedge clk);
      chk("R10", "no read when stopped", 64'(nreads), 64'd0);
      chk("R10", "ch_run stays 0", 64'(ch_run), 64'd0);
      chk("R10", "done unchanged", 64'(chain_done), 64'd1);
      chk("R10", "err unchanged", 64'(chain_err), 64'd0);
      chk("R10", "ctrl unchanged", 64'(ch_ctrl), 64'h0102_9005);
   endtask

   task automatic t_fetch_error();
      load_init(32'hC0DE_0001, 32'h4, 64'h3000, 64'h4000, 64'h180);
      chk("R2", "done cleared by load", 64'(chain_done), 64'd0);
      err_addr = 64'h18C;
      nreads = 0;
      pulse_done();
      repeat (12) @(negedge clk);
      chk("R8", "reads before error", 64'(nreads), 64'd4);
      chk("R8", "chain_err", 64'(chain_err), 64'd1);
      chk("R8", "ch_run stays 0", 64'(ch_run), 64'd0);
      chk("R8", "rd_req dropped", 64'(rd_req), 64'd0);
      chk("R8", "ctrl kept", 64'(ch_ctrl), 64'hC0DE_0001);
      chk("R8", "link kept", ch_link, 64'h180);
      chk("R8", "done not set", 64'(chain_done), 64'd0);
      err_addr = '1;
      load_init(32'h1, 32'h1, 64'h0, 64'h0, 64'h0);
      chk("R2", "err cleared by load", 64'(chain_err), 64'd0);
   endtask

   task automatic t_misaligned();
      load_init(32'h2, 32'h2, 64'h10, 64'h20, 64'h104);
      nreads = 0;
      pulse_done();
      repeat (5) @(negedge clk);
      chk("R9", "no read on misaligned link", 64'(nreads), 64'd0);
      chk("R9", "chain_err", 64'(chain_err), 64'd1);
      chk("R9", "ch_run stopped", 64'(ch_run), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      t_reset();
      t_chain();
      t_ignore_idle();
      t_fetch_error();
      t_misaligned();
      repeat (2) @(negedge clk);
      report();
   end
endmodule